// File: doc/BRIEF.md
# Up-Down PWM Generator with Sync Chain

This block drives two PWM outputs, A and B, from a single triangle timebase. The counter rises from zero to a programmable period and then falls back to zero, so a full cycle lasts twice the period value. The period and both compare values are written to shadow copies first. A shadow copy moves to its active register only in a clock in which the counter reads zero, so a new duty or period never takes effect in the middle of a cycle.

Each output has an action table. It decides whether the output is left alone, cleared, set or toggled on each of six counter events. Several blocks can be run in lockstep. An upstream block emits a sync pulse at zero, or passes its own sync input through. A downstream block with phase loading enabled jumps to its phase value on that pulse and then keeps counting up. Software configures the block through a simple write port made of an enable, an address and data.

Top module: `pwm_updown_sync`

## Requirements
- R1: After reset the counter, both PWM outputs and sync_out are 0. The counter holds its value while control field bits [1:0] (address 0) differ from 01, and it runs only when that field is 01.
- R2: While running, the counter goes up by one per clock until it equals the active period, then goes down by one per clock to 0, then up again. A period P gives a cycle of 2P clocks.
- R3: A write to the period (address 1) reaches the active period only at the end of a clock in which the counter is 0.
- R4: Writes to compare A (address 3) and compare B (address 4) reach their active values only at the end of a clock in which the counter is 0.
- R5: Output A is configured at address 5 and output B at address 6. Each has six 2-bit fields: [1:0] zero, [3:2] period, [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling. The codes are 00 none, 01 clear, 10 set and 11 toggle. The output shows the result one clock after the counter shows the event. "Rising" means the counter is counting up, which includes the clock at the period value.
- R6: When several events with a non-zero code fall in the same clock, compare B wins over compare A, compare A wins over period, and period wins over zero.
- R7: With control bit 2 set, sync_in high in a running clock loads the phase value (address 2) into the counter for the next clock, and counting continues upward from there.
- R8: With control bit 2 clear, sync_in has no effect on the counter.
- R9: With control bit 3 clear, sync_out is high for exactly the one clock after a running clock in which the counter is 0. With bit 3 set, sync_out equals sync_in delayed by one clock.
- R10: While stopped, neither PWM output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Sync from an upstream block |
| sync_out | output | 1 | Sync toward a downstream block |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| count | output | 16 | Timebase counter value |

## Verification
A wrong counter direction or a missed turn shows on count within one clock. It then shifts every later zero pulse on sync_out. An active register loaded at the wrong time moves a PWM edge within the same cycle, and the edge lands one clock after the counter passes the stale compare value. A bad priority or action decode flips pwm_a or pwm_b on the very clock after a coinciding event. A cycle-by-cycle reference model, compared on every clock, therefore catches each of these within at most one triangle period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ACT_NOP = 2'b00,
    ACT_CLR = 2'b01,
    ACT_SET = 2'b10,
    ACT_TGL = 2'b11
  } act_e;

  localparam int NUM_EVT  = 6;
  localparam int CFG_W    = 2 * NUM_EVT;
  localparam int NUM_CMP  = 2;
  localparam int NUM_OUT  = 2;

  // event index order doubles as ascending priority
  localparam int EV_ZRO = 0;
  localparam int EV_PRD = 1;
  localparam int EV_CAU = 2;
  localparam int EV_CAD = 3;
  localparam int EV_CBU = 4;
  localparam int EV_CBD = 5;

  localparam int ADR_CTRL = 0;
  localparam int ADR_PRD  = 1;
  localparam int ADR_PHS  = 2;
  localparam int ADR_CMP0 = 3;
  localparam int ADR_ACT0 = 5;

  localparam logic [1:0] MODE_UPDN = 2'b01;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cnt_zero,
  output logic              run,
  output logic              ph_en,
  output logic              sel_flow,
  output logic [CNT_W-1:0]  prd_act,
  output logic [CNT_W-1:0]  phase_val,
  output logic [CNT_W-1:0]  cmpa_act,
  output logic [CNT_W-1:0]  cmpb_act,
  output logic [CFG_W-1:0]  cfg_a,
  output logic [CFG_W-1:0]  cfg_b
);
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] prd_sh;
  logic [CNT_W-1:0] cmp_sh  [NUM_CMP];
  logic [CNT_W-1:0] cmp_act [NUM_CMP];
  logic [CFG_W-1:0] cfg_q   [NUM_OUT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      ph_en     <= 1'b0;
      sel_flow  <= 1'b0;
      prd_sh    <= '0;
      prd_act   <= '0;
      phase_val <= '0;
    end else begin
      if (cnt_zero) prd_act <= prd_sh;
      if (wr_en) begin
        if (wr_addr == ADDR_W'(ADR_CTRL)) begin
          mode_q   <= wr_data[1:0];
          ph_en    <= wr_data[2];
          sel_flow <= wr_data[3];
        end
        if (wr_addr == ADDR_W'(ADR_PRD)) prd_sh    <= wr_data;
        if (wr_addr == ADDR_W'(ADR_PHS)) phase_val <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_sh[g]  <= '0;
        cmp_act[g] <= '0;
      end else begin
        if (cnt_zero) cmp_act[g] <= cmp_sh[g];
        if (wr_en && wr_addr == ADDR_W'(ADR_CMP0 + g)) cmp_sh[g] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfg_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ADR_ACT0 + g)) cfg_q[g] <= wr_data[CFG_W-1:0];
    end
  end

  assign run      = (mode_q == MODE_UPDN);
  assign cmpa_act = cmp_act[0];
  assign cmpb_act = cmp_act[1];
  assign cfg_a    = cfg_q[0];
  assign cfg_b    = cfg_q[1];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ph_en,
  input  logic             sel_flow,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] phase,
  input  logic             sync_in,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             sync_out
);
  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      dir_up   <= 1'b1;
      sync_out <= 1'b0;
    end else begin
      sync_out <= sel_flow ? sync_in : (run && at_zero);
      if (run) begin
        if (ph_en && sync_in) begin
          count  <= phase;
          dir_up <= 1'b1;
        end else if (dir_up) begin
          if (count >= prd) begin
            dir_up <= 1'b0;
            count  <= at_zero ? count : count - 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else begin
          if (at_zero) begin
            dir_up <= 1'b1;
            count  <= (prd == '0) ? '0 : CNT_W'(1);
          end else begin
            count <= count - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic [CFG_W-1:0] cfg,
  output logic             out
);
  logic [NUM_EVT-1:0] ev;
  act_e               pick;

  always_comb begin
    ev         = '0;
    ev[EV_ZRO] = (count == '0);
    ev[EV_PRD] = (count == prd);
    ev[EV_CAU] = (count == cmpa) && dir_up;
    ev[EV_CAD] = (count == cmpa) && !dir_up;
    ev[EV_CBU] = (count == cmpb) && dir_up;
    ev[EV_CBD] = (count == cmpb) && !dir_up;
  end

  // later index overrides earlier: ascending priority
  always_comb begin
    pick = ACT_NOP;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (ev[i] && act_e'(cfg[2*i +: 2]) != ACT_NOP) pick = act_e'(cfg[2*i +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b0;
    end else if (run) begin
      unique case (pick)
        ACT_CLR: out <= 1'b0;
        ACT_SET: out <= 1'b1;
        ACT_TGL: out <= ~out;
        default: out <= out;
      endcase
    end
  end
endmodule

// File: rtl/pwm_updown_sync.sv
module pwm_updown_sync
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              sync_in,
  output logic              sync_out,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [CNT_W-1:0]  count
);
  logic             run, ph_en, sel_flow, dir_up;
  logic [CNT_W-1:0] prd_act, phase_val, cmpa_act, cmpb_act;
  logic [CFG_W-1:0] cfg_a, cfg_b;
  logic [CFG_W-1:0] cfg_w [NUM_OUT];
  logic             out_w [NUM_OUT];

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_zero(count == '0), .run(run), .ph_en(ph_en), .sel_flow(sel_flow),
    .prd_act(prd_act), .phase_val(phase_val), .cmpa_act(cmpa_act),
    .cmpb_act(cmpb_act), .cfg_a(cfg_a), .cfg_b(cfg_b)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .ph_en(ph_en), .sel_flow(sel_flow),
    .prd(prd_act), .phase(phase_val), .sync_in(sync_in),
    .count(count), .dir_up(dir_up), .sync_out(sync_out)
  );

  assign cfg_w[0] = cfg_a;
  assign cfg_w[1] = cfg_b;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_action #(.CNT_W(CNT_W)) u_aq (
      .clk(clk), .rst(rst), .run(run), .count(count), .dir_up(dir_up),
      .prd(prd_act), .cmpa(cmpa_act), .cmpb(cmpb_act), .cfg(cfg_w[g]),
      .out(out_w[g])
    );
  end

  assign pwm_a = out_w[0];
  assign pwm_b = out_w[1];
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ph_en,
  input logic             sel_flow,
  input logic             sync_in,
  input logic             sync_out,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] phase_val
);
  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> count == $past(count));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !(ph_en && sync_in) && count != '0 && count < prd_act)
    |=> (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

  // R7
  phase_load_chk: assert property (@(posedge clk) disable iff (rst)
    (run && ph_en && sync_in) |=> count == $past(phase_val));

  // R9
  flow_through_chk: assert property (@(posedge clk) disable iff (rst)
    sel_flow |=> sync_out == $past(sync_in));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pwm_a) && $stable(pwm_b)));
endmodule

bind pwm_updown_sync pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ph_en(ph_en), .sel_flow(sel_flow),
  .sync_in(sync_in), .sync_out(sync_out), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .count(count), .prd_act(prd_act), .phase_val(phase_val)
);

// File: tb/sim_pwm_updown_sync.sv
`timescale 1ns/1ps
module sim_pwm_updown_sync;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         sync_in = 1'b0;
  logic         sync_out, pwm_a, pwm_b;
  logic [W-1:0] count;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_updown_sync u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .sync_out(sync_out), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .count(count)
  );

  typedef struct packed {
    logic [W-1:0] c;
    logic         a;
    logic         b;
    logic         s;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [1:0]   m_mode;
  bit           m_phen, m_sel, m_up, m_a, m_b, m_s;
  logic [W-1:0] m_cnt, sh_prd, sh_ca, sh_cb, ac_prd, ac_ca, ac_cb, m_phs;
  logic [11:0]  m_cfa, m_cfb;

  function automatic bit apply(logic [1:0] code, bit cur);
    if (code == 2'b01) return 1'b0;
    if (code == 2'b10) return 1'b1;
    if (code == 2'b11) return !cur;
    return cur;
  endfunction

  function automatic bit qual(logic [11:0] cf, bit cur);
    logic [1:0] code;
    code = m_up ? cf[9:8] : cf[11:10];
    if (m_cnt == ac_cb && code != 2'b00) return apply(code, cur);
    code = m_up ? cf[5:4] : cf[7:6];
    if (m_cnt == ac_ca && code != 2'b00) return apply(code, cur);
    if (m_cnt == ac_prd && cf[3:2] != 2'b00) return apply(cf[3:2], cur);
    if (m_cnt == 0 && cf[1:0] != 2'b00) return apply(cf[1:0], cur);
    return cur;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_mode = 0; m_phen = 0; m_sel = 0; m_up = 1; m_a = 0; m_b = 0; m_s = 0;
      m_cnt = 0; sh_prd = 0; sh_ca = 0; sh_cb = 0; ac_prd = 0; ac_ca = 0; ac_cb = 0;
      m_phs = 0; m_cfa = 0; m_cfb = 0;
    end else begin
      bit running, was_zero, na, nb;
      running  = (m_mode == 2'b01);
      was_zero = (m_cnt == 0);
      na = m_a; nb = m_b;
      if (running) begin na = qual(m_cfa, m_a); nb = qual(m_cfb, m_b); end
      m_s = m_sel ? sync_in : (running && was_zero);
      if (running) begin
        if (m_phen && sync_in) begin m_cnt = m_phs; m_up = 1; end
        else if (m_up && m_cnt < ac_prd) m_cnt = m_cnt + 1;
        else if (m_up) begin m_up = 0; if (m_cnt != 0) m_cnt = m_cnt - 1; end
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        else begin m_up = 1; m_cnt = (ac_prd == 0) ? 0 : 1; end
      end
      m_a = na; m_b = nb;
      if (was_zero) begin ac_prd = sh_prd; ac_ca = sh_ca; ac_cb = sh_cb; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[1:0]; m_phen = wr_data[2]; m_sel = wr_data[3]; end
          3'd1: sh_prd = wr_data;
          3'd2: m_phs = wr_data;
          3'd3: sh_ca = wr_data;
          3'd4: sh_cb = wr_data;
          3'd5: m_cfa = wr_data[11:0];
          3'd6: m_cfb = wr_data[11:0];
          default: ;
        endcase
      end
    end
    q.push_back('{c: m_cnt, a: m_a, b: m_b, s: m_s});
  end

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (count !== e.c) begin
        n_bad++;
        $display("FAIL R1 R2 R3 R7 R8 count cyc=%0d actual=%0d expected=%0d", cyc, count, e.c);
      end
      n_cmp++;
      if (pwm_a !== e.a) begin
        n_bad++;
        $display("FAIL R4 R5 R6 R10 pwm_a cyc=%0d actual=%0b expected=%0b", cyc, pwm_a, e.a);
      end
      n_cmp++;
      if (pwm_b !== e.b) begin
        n_bad++;
        $display("FAIL R4 R5 R6 R10 pwm_b cyc=%0d actual=%0b expected=%0b", cyc, pwm_b, e.b);
      end
      n_cmp++;
      if (sync_out !== e.s) begin
        n_bad++;
        $display("FAIL R9 sync_out cyc=%0d actual=%0b expected=%0b", cyc, sync_out, e.s);
      end
    end
  end

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  initial begin
    int t0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 pwm_a after reset", int'(pwm_a), 0);
    chk("R1 sync_out after reset", int'(sync_out), 0);
    // configure while stopped
    wr(1, 10); wr(3, 4); wr(4, 6);
    wr(5, 12'h012);          // R5: zero set, compare A rising clear
    wr(6, 12'h801);          // R5: zero clear, compare B falling set
    idle(4);
    chk("R1 counter held while stopped", int'(count), 0);
    wr(0, 1);                // run, zero-pulse sync
    // R2 / R9: pulses 2P = 20 clocks apart, one clock wide
    while (sync_out !== 1'b1) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    chk("R9 zero pulse width", int'(sync_out), 0);
    while (sync_out !== 1'b1) @(negedge clk);
    chk("R2 triangle cycle length", cyc - t0, 20);
    // R3 / R4: mid-cycle shadow writes, scoreboard checks load point
    idle(5);
    wr(1, 6); wr(3, 2); wr(4, 5);
    idle(40);
    // R6: compare A falling at zero beats zero set; R5 toggle on period for B
    wr(3, 0);
    wr(5, 12'h042);
    wr(6, 12'h00C);
    idle(40);
    // R7: phase load
    wr(2, 3);
    wr(0, 5);
    pulse_sync();
    chk("R7 phase loaded", int'(count), 3);
    idle(15);
    // R8: phase disabled, sync ignored (scoreboard)
    wr(0, 1);
    pulse_sync();
    idle(10);
    // R9: flow-through
    wr(0, 9);
    pulse_sync();
    chk("R9 flow-through delayed copy", int'(sync_out), 1);
    @(negedge clk);
    chk("R9 flow-through falls", int'(sync_out), 0);
    idle(5);
    // R1 / R10: stop holds counter and outputs
    wr(0, 0);
    t0 = int'(count);
    idle(8);
    chk("R1 counter held after stop", int'(count), t0);
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule